// File: doc/BRIEF.md
# Consecutive-Cycle Digital Lock Detector

The block watches the phase alignment of a frequency synthesizer loop. Once per phase-detector cycle an upstream measurement stage gives a phase-error magnitude, counted in system-clock ticks, and pulses a valid strobe with it. The block uses these samples to drive a registered, active-high lock flag.

Lock uses hysteresis. A sample below a tight acquire threshold counts as good. A sample above a looser release threshold counts as bad. Anything in between counts as marginal. While unlocked, the flag rises only after an unbroken run of good samples. A mode input sets the run length to three (mode 0) or five (mode 1). While locked, a single bad sample drops the flag at once. Marginal samples never drop it.

Both thresholds and both run lengths are parameters. The release threshold must not be below the acquire threshold.

Top module: `digital_lock_detector`

## Requirements
- R1: While the synchronous active-high reset is high, and on the first cycle after it, the lock flag is 0 and the run count is zero.
- R2: With the mode input at 0, three consecutive valid samples whose error is strictly below ACQ_TICKS (default 15) raise the lock flag. The flag rises on the clock edge that captures the third sample.
- R3: With the mode input at 1, five such consecutive samples are needed, and four leave the flag low.
- R4: While unlocked, a valid sample whose error is greater than or equal to ACQ_TICKS resets the run count to zero. An error exactly equal to ACQ_TICKS counts as not good.
- R5: While locked, a single valid sample whose error is strictly above REL_TICKS (default 25) clears the flag on the edge that captures it.
- R6: While locked, valid samples whose error lies from ACQ_TICKS up to and including REL_TICKS leave the flag set. Good samples also leave it set.
- R7: After lock is lost, reacquiring it needs a complete new run of good samples. No count carries over from before or during lock.
- R8: Cycles with the valid strobe low change neither the flag nor the run count, whatever the error input holds.
- R9: A change of the mode input while unlocked restarts the run count. A valid good sample in the same cycle counts as the first of the new run. While locked, a mode change has no effect on the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| err_valid | input | 1 | Strobe: err_ticks holds a new phase-error sample this cycle |
| err_ticks | input | ERR_W | Phase-error magnitude in system-clock ticks |
| long_mode | input | 1 | 0: three-sample acquire run, 1: five-sample run |
| lock_o | output | 1 | Registered lock flag, active high |

## Verification
The assertions assume the following about the inputs:
- There is at most one error sample per valid strobe.
- The error value and the mode bit are stable over the edge that captures them.
- The reset is held for at least one edge at start-up.

The bench drives every input on the falling clock edge, so each sample is captured by exactly one rising edge. It changes the mode bit only in cycles with the strobe low. This keeps the run-restart cases separate from the marginal and bad sample cases. Error values are placed on and next to both thresholds (14, 15, 25, 26) to pin down which comparisons are strict.

// File: rtl/lock_det_pkg.sv
package lock_det_pkg;
  typedef enum logic [1:0] {
    ERR_GOOD = 2'd0,
    ERR_MID  = 2'd1,
    ERR_BAD  = 2'd2
  } err_class_t;
endpackage

// File: rtl/err_classifier.sv
module err_classifier
  import lock_det_pkg::*;
#(
  parameter int ERR_W     = 8,
  parameter int ACQ_TICKS = 15,
  parameter int REL_TICKS = 25
) (
  input  logic [ERR_W-1:0] err_ticks,
  output err_class_t       err_cls
);
  localparam logic [ERR_W-1:0] ACQ_L = ERR_W'(ACQ_TICKS);
  localparam logic [ERR_W-1:0] REL_L = ERR_W'(REL_TICKS);

  always_comb begin
    if (err_ticks < ACQ_L)      err_cls = ERR_GOOD;
    else if (err_ticks > REL_L) err_cls = ERR_BAD;
    else                        err_cls = ERR_MID;
  end
endmodule

// File: rtl/good_run_counter.sv
module good_run_counter
  import lock_det_pkg::*;
#(
  parameter int SHORT_RUN = 3,
  parameter int LONG_RUN  = 5,
  parameter int CNT_W     = $clog2(LONG_RUN + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sample_valid,
  input  err_class_t sample_cls,
  input  logic       locked,
  input  logic       long_mode,
  output logic       run_done
);
  localparam logic [CNT_W-1:0] SHORT_L = CNT_W'(SHORT_RUN);
  localparam logic [CNT_W-1:0] LONG_L  = CNT_W'(LONG_RUN);

  logic [CNT_W-1:0] run_q, run_d, base, target;
  logic             mode_q;
  logic             restart;

  assign target  = long_mode ? LONG_L : SHORT_L;
  assign restart = (long_mode != mode_q);
  assign base    = restart ? '0 : run_q;

  always_comb begin
    run_done = 1'b0;
    run_d    = base;
    if (locked) begin
      run_d = '0;
    end else if (sample_valid) begin
      if (sample_cls == ERR_GOOD) begin
        if (base + CNT_W'(1) == target) begin
          run_done = 1'b1;
          run_d    = '0;
        end else begin
          run_d = base + CNT_W'(1);
        end
      end else begin
        run_d = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= '0;
      mode_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      mode_q <= long_mode;
    end
  end

  // R4: a non-good sample while unlocked empties the run
  assert_nongood_clears_R4: assert property (@(posedge clk) disable iff (rst)
    (!locked && sample_valid && sample_cls != ERR_GOOD) |=> (run_q == '0));

  // R3: the run never reaches the longest target without having completed
  assert_run_bounded_R3: assert property (@(posedge clk) disable iff (rst)
    run_q < LONG_L);

  // R7: no run is kept while locked
  assert_locked_run_empty_R7: assert property (@(posedge clk) disable iff (rst)
    locked |-> (run_q == '0));

  // R8: idle cycles leave the run untouched when the mode is steady
  assert_idle_holds_R8: assert property (@(posedge clk) disable iff (rst)
    (!sample_valid && !locked && long_mode == mode_q) |=> $stable(run_q));
endmodule

// File: rtl/lock_state.sv
module lock_state
  import lock_det_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sample_valid,
  input  err_class_t sample_cls,
  input  logic       run_done,
  output logic       locked
);
  logic lock_d;

  always_comb begin
    if (locked) lock_d = !(sample_valid && sample_cls == ERR_BAD);
    else        lock_d = run_done;
  end

  always_ff @(posedge clk) begin
    if (rst) locked <= 1'b0;
    else     locked <= lock_d;
  end

  // R2: lock only rises on a completed run
  assert_rise_on_run_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(run_done));
endmodule

// File: rtl/digital_lock_detector.sv
module digital_lock_detector
  import lock_det_pkg::*;
#(
  parameter int ERR_W     = 8,
  parameter int ACQ_TICKS = 15,
  parameter int REL_TICKS = 25,
  parameter int SHORT_RUN = 3,
  parameter int LONG_RUN  = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             err_valid,
  input  logic [ERR_W-1:0] err_ticks,
  input  logic             long_mode,
  output logic             lock_o
);
  localparam int CNT_W = $clog2(LONG_RUN + 1);
  localparam logic [ERR_W-1:0] ACQ_L = ERR_W'(ACQ_TICKS);
  localparam logic [ERR_W-1:0] REL_L = ERR_W'(REL_TICKS);

  err_class_t cls;
  logic       run_done;
  logic       locked;

  err_classifier #(
    .ERR_W(ERR_W), .ACQ_TICKS(ACQ_TICKS), .REL_TICKS(REL_TICKS)
  ) u_cls (
    .err_ticks(err_ticks),
    .err_cls  (cls)
  );

  good_run_counter #(
    .SHORT_RUN(SHORT_RUN), .LONG_RUN(LONG_RUN), .CNT_W(CNT_W)
  ) u_run (
    .clk         (clk),
    .rst         (rst),
    .sample_valid(err_valid),
    .sample_cls  (cls),
    .locked      (locked),
    .long_mode   (long_mode),
    .run_done    (run_done)
  );

  lock_state u_lock (
    .clk         (clk),
    .rst         (rst),
    .sample_valid(err_valid),
    .sample_cls  (cls),
    .run_done    (run_done),
    .locked      (locked)
  );

  assign lock_o = locked;

  // R2: a rising flag follows a captured sample below the acquire threshold
  assert_rise_after_good_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_o) |-> $past(err_valid && err_ticks < ACQ_L));

  // R5: a falling flag follows a captured sample above the release threshold
  assert_fall_after_bad_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(lock_o) |-> $past(err_valid && err_ticks > REL_L));

  // R6: marginal or good samples keep lock
  assert_hold_in_band_R6: assert property (@(posedge clk) disable iff (rst)
    (lock_o && err_valid && err_ticks <= REL_L) |=> lock_o);

  // R8: idle cycles never move the flag
  assert_idle_flag_R8: assert property (@(posedge clk) disable iff (rst)
    !err_valid |=> $stable(lock_o));
endmodule

// File: tb/tb_digital_lock_detector.sv
module tb_digital_lock_detector;
  localparam int ERR_W = 8;
  localparam int ACQ = 15;
  localparam int REL = 25;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic err_valid = 1'b0;
  logic [ERR_W-1:0] err_ticks = '0;
  logic long_mode = 1'b0;
  logic lock_o;

  int n_vec = 0;
  int n_bad = 0;
  bit    exp_q[$];
  string tag_q[$];

  // reference state built from the requirements
  bit m_lock = 0;
  int m_run  = 0;
  bit m_mode = 0;

  always #10 clk = ~clk;

  digital_lock_detector #(.ERR_W(ERR_W), .ACQ_TICKS(ACQ), .REL_TICKS(REL)) dut (
    .clk(clk), .rst(rst), .err_valid(err_valid), .err_ticks(err_ticks),
    .long_mode(long_mode), .lock_o(lock_o)
  );

  task automatic apply(input bit v, input int e, input bit md, input string tag);
    int tgt;
    @(negedge clk);
    err_valid = v;
    err_ticks = ERR_W'(e);
    long_mode = md;
    if (md != m_mode && !m_lock) m_run = 0;  // R9
    m_mode = md;
    tgt = md ? 5 : 3;
    if (v) begin
      if (m_lock) begin
        if (e > REL) begin m_lock = 0; m_run = 0; end
      end else if (e < ACQ) begin
        m_run++;
        if (m_run == tgt) begin m_lock = 1; m_run = 0; end
      end else begin
        m_run = 0;
      end
    end
    exp_q.push_back(m_lock);
    tag_q.push_back(tag);
  endtask

  task automatic goods(input int n, input bit md, input string tag);
    for (int i = 0; i < n; i++) apply(1, 3 + i, md, tag);
  endtask

  always @(posedge clk) begin
    #5;
    if (exp_q.size() > 0) begin
      bit    ex;
      string tg;
      ex = exp_q.pop_front();
      tg = tag_q.pop_front();
      n_vec++;
      if (lock_o !== ex) begin
        n_bad++;
        $display("FAIL %s: lock_o=%b expected %b at %0t", tg, lock_o, ex, $time);
      end
    end
  end

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_vec++;
    if (lock_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: lock_o=%b expected 0 in reset", lock_o);
    end
    rst = 1'b0;
    apply(0, 0, 0, "R1");
    // R2: three good samples in short mode
    goods(3, 0, "R2");
    // R6: marginal samples, including both threshold edges, keep lock
    apply(1, 15, 0, "R6");
    apply(1, 20, 0, "R6");
    apply(1, 25, 0, "R6");
    // R8: idle with a huge error does nothing
    apply(0, 200, 0, "R8");
    // R9: mode change while locked ignored
    apply(0, 0, 1, "R9");
    apply(0, 0, 0, "R9");
    // R5: one bad sample drops lock
    apply(1, 26, 0, "R5");
    // R7: full run needed again
    goods(2, 0, "R7");
    apply(1, 4, 0, "R7");
    apply(1, 100, 0, "R5");
    // R4: error equal to acquire threshold breaks the run
    goods(2, 0, "R4");
    apply(1, 15, 0, "R4");
    goods(2, 0, "R4");
    apply(1, 14, 0, "R4");
    apply(1, 30, 0, "R5");
    // R3: long mode needs five
    apply(0, 0, 1, "R3");
    goods(4, 1, "R3");
    apply(1, 1, 1, "R3");
    apply(1, 255, 1, "R5");
    // R8: idle gap inside a run does not break it
    goods(2, 1, "R8");
    apply(0, 99, 1, "R8");
    apply(0, 20, 1, "R8");
    goods(3, 1, "R8");
    apply(1, 40, 1, "R5");
    // R9: mode change while unlocked restarts the run
    goods(3, 1, "R9");
    apply(0, 0, 0, "R9");
    goods(2, 0, "R9");
    apply(1, 0, 0, "R9");
    apply(1, 26, 0, "R5");
    // R9: switch to long mode after two short-mode goods
    goods(2, 0, "R9");
    apply(0, 0, 1, "R9");
    goods(4, 1, "R9");
    apply(1, 2, 1, "R9");
    apply(0, 0, 1, "R8");
    repeat (3) @(posedge clk);
    #6;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule